// File: doc/BRIEF.md
# EEPROM Page-Splitting Write Sequencer

This block is an SPI master for a serial EEPROM whose array is organised in 32-byte pages. A client asks for a write of any length at any 16-bit start address and streams the data bytes in through a ready/valid port. The sequencer cuts the block into pieces that never cross a page boundary, so the EEPROM's page address counter never wraps inside a page. Before each piece it sends a write-enable command in its own chip-select frame. It then sends the write command, the address and the data. After that it polls the status register, one frame per read, until the write-in-progress bit is clear.

The serial clock runs in mode 0 and is derived from the system clock by a divider parameter. The chip select stays high for a parameterised minimum number of cycles between frames. If the EEPROM stays busy for more consecutive status reads than the limit allows, the sequencer gives up, raises an error flag and returns to idle. A finished request gives a one-cycle done pulse.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, and busy, done, err and in_ready are 0. A start seen while idle with a nonzero length raises busy on the next cycle. A start with length 0 produces a done pulse on the next cycle and no frame.
- R2: Serial transfers use SPI mode 0. sclk is 0 whenever cs_n is 1. Each byte is sent most significant bit first, and mosi changes only while sclk is low. Each sclk level lasts at least CLK_DIV system clocks, and every frame holds a whole number of bytes.
- R3: Each chunk is preceded by a frame that carries only the write-enable byte 0x06.
- R4: The data frame of a chunk carries 0x02, then the address high byte, then the address low byte, then the chunk's data bytes in input order.
- R5: The first chunk has min(len, 32 - addr mod 32) bytes. Each later chunk starts on a 32-byte boundary and has min(remaining, 32) bytes. The address wraps modulo 2^16.
- R6: After each data frame the block sends status frames of two bytes, 0x05 and then a dummy 0x00, and reads the second byte from miso. It repeats them until bit 0 of that byte is 0. No other frame starts before that read.
- R7: cs_n stays high for at least CS_GAP system clocks before every frame.
- R8: in_ready is high only while the block waits for a data byte inside a data frame. A byte is taken when in_valid and in_ready are both high.
- R9: When the last chunk's status read shows bit 0 clear, done pulses for exactly one cycle and busy falls in the same cycle.
- R10: POLL_LIMIT consecutive status reads with bit 0 set end the request. err then rises, busy falls and done does not pulse. err stays high until the next accepted start clears it.
- R11: start is ignored while busy. It has no effect on the frames of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken while idle |
| start_addr | input | 16 | First EEPROM byte address |
| start_len | input | LEN_W | Number of bytes to write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when a request finishes |
| err | output | 1 | Status polling timed out; held until the next start |
| in_valid | input | 1 | Data byte available |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Block accepts a data byte |
| cs_n | output | 1 | EEPROM chip select, active low |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the EEPROM |
| miso | input | 1 | Serial data from the EEPROM |

## Verification
On every cycle, the bound checker enforces the clock-level rules: sclk idle while deselected, the minimum sclk level time, the chip-select gap before each frame, in_ready only inside a frame, and the shape of done. The byte-level order of frames needs the bench's EEPROM model, which decodes each frame and compares it with a sequence it builds from the requirements. That order covers the page split, address wrap, write-enable placement and the number of status polls. The bench scenarios alone show the timeout path, error clearing, the zero-length request and a start ignored in mid-request.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int CLK_DIV    = 3,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 4096,
  parameter int PAGE_BYTES = 32,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      start_addr,
  input  logic [LEN_W-1:0] start_len,
  output logic             busy,
  output logic             done,
  output logic             err,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CHK_W  = PAGE_W + 1;
  localparam int DIV_W  = $clog2(CLK_DIV + 1);
  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_XFER, S_WAITD} st_t;
  typedef enum logic [2:0] {P_WREN, P_WCMD, P_AH, P_AL, P_DATA, P_RCMD, P_RSTAT} ph_t;

  st_t              st;
  ph_t              ph, nxt;
  logic [DIV_W-1:0] div;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic             wip;
  logic [GAP_W-1:0] gcnt;
  logic [POLL_W-1:0] poll;
  logic [15:0]      addr;
  logic [LEN_W-1:0] rem;
  logic [CHK_W-1:0] ccnt, room, chunk;
  logic [7:0]       op;
  logic             tick;

  assign busy     = (st != S_IDLE);
  assign in_ready = (st == S_WAITD);
  assign mosi     = cs_n ? 1'b0 : sh[7];
  assign tick     = (div == DIV_W'(CLK_DIV - 1));
  assign room     = CHK_W'(PAGE_BYTES) - CHK_W'(addr[PAGE_W-1:0]);
  assign chunk    = (rem < LEN_W'(room)) ? CHK_W'(rem) : room;

  always_comb begin
    case (nxt)
      P_WREN:  op = 8'h06;
      P_WCMD:  op = 8'h02;
      P_RCMD:  op = 8'h05;
      default: op = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= P_WREN;
      nxt  <= P_WREN;
      div  <= '0;
      bitn <= '0;
      sh   <= '0;
      wip  <= 1'b0;
      gcnt <= '0;
      poll <= '0;
      addr <= '0;
      rem  <= '0;
      ccnt <= '0;
      cs_n <= 1'b1;
      sclk <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            err  <= 1'b0;
            addr <= start_addr;
            rem  <= start_len;
            if (start_len == '0) begin
              done <= 1'b1;
            end else begin
              st   <= S_GAP;
              gcnt <= '0;
              nxt  <= P_WREN;
            end
          end
        end
        S_GAP: begin
          if (gcnt == GAP_W'(CS_GAP - 1)) begin
            st   <= S_XFER;
            cs_n <= 1'b0;
            ph   <= nxt;
            sh   <= op;
            div  <= '0;
            bitn <= '0;
            if (nxt == P_WREN) ccnt <= chunk;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_WAITD: begin
          if (in_valid) begin
            sh   <= in_data;
            st   <= S_XFER;
            div  <= '0;
            bitn <= '0;
          end
        end
        S_XFER: begin
          if (!tick) begin
            div <= div + 1'b1;
          end else begin
            div <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              wip  <= miso;
            end else begin
              sclk <= 1'b0;
              sh   <= {sh[6:0], 1'b0};
              bitn <= bitn + 3'd1;
              if (bitn == 3'd7) begin
                case (ph)
                  P_WREN: begin
                    cs_n <= 1'b1;
                    st   <= S_GAP;
                    gcnt <= '0;
                    nxt  <= P_WCMD;
                  end
                  P_WCMD: begin
                    ph <= P_AH;
                    sh <= addr[15:8];
                  end
                  P_AH: begin
                    ph <= P_AL;
                    sh <= addr[7:0];
                  end
                  P_AL: begin
                    ph <= P_DATA;
                    st <= S_WAITD;
                  end
                  P_DATA: begin
                    addr <= addr + 16'd1;
                    rem  <= rem - 1'b1;
                    ccnt <= ccnt - 1'b1;
                    if (ccnt == CHK_W'(1)) begin
                      cs_n <= 1'b1;
                      st   <= S_GAP;
                      gcnt <= '0;
                      nxt  <= P_RCMD;
                      poll <= '0;
                    end else begin
                      st <= S_WAITD;
                    end
                  end
                  P_RCMD: begin
                    ph <= P_RSTAT;
                    sh <= 8'h00;
                  end
                  default: begin
                    cs_n <= 1'b1;
                    if (!wip) begin
                      if (rem == '0) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                      end else begin
                        st   <= S_GAP;
                        gcnt <= '0;
                        nxt  <= P_WREN;
                      end
                    end else if (poll == POLL_W'(POLL_LIMIT - 1)) begin
                      st  <= S_IDLE;
                      err <= 1'b1;
                    end else begin
                      poll <= poll + 1'b1;
                      st   <= S_GAP;
                      gcnt <= '0;
                      nxt  <= P_RCMD;
                    end
                  end
                endcase
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int CLK_DIV = 3,
  parameter int CS_GAP  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic in_ready,
  input logic done,
  input logic err,
  input logic busy
);
  logic        sclk_q;
  logic [15:0] srun, hrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      srun   <= 16'hFFFF;
      hrun   <= '0;
    end else begin
      sclk_q <= sclk;
      if (sclk != sclk_q) srun <= 16'd1;
      else if (srun != 16'hFFFF) srun <= srun + 16'd1;
      if (!cs_n) hrun <= '0;
      else if (hrun != 16'hFFFF) hrun <= hrun + 16'd1;
    end
  end

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_sclk_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_q) |-> (srun >= 16'(CLK_DIV)));

  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hrun >= 16'(CS_GAP)));

  p_ready_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cs_n);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .in_ready(in_ready), .done(done), .err(err), .busy(busy)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb_top;
  localparam int DIV  = 3;
  localparam int GAP  = 4;
  localparam int PLIM = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [15:0] start_len = '0;
  logic        busy, done, err, in_ready, cs_n, sclk, mosi;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        miso = 1'b0;

  always #10 clk = ~clk;

  eeprom_page_writer #(.CLK_DIV(DIV), .CS_GAP(GAP), .POLL_LIMIT(PLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .done(done), .err(err),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int   exp_len[$];
  int   exp_b[$];
  int   data_q[$];
  int   rx_b[$];
  int   bitcnt = 0;
  int   sh_in = 0;
  int   wip_left = 0;
  int   busy_cfg = 0;
  int   hi_cnt = 0;
  int   cyc = 0;
  bit   stall_en = 0;
  bit   hs_pend = 0;
  logic prev_cs = 1'b1;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R9: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (rst_n) begin
      if (cs_n) chk("R2", "sclk idle while deselected", int'(sclk), 0);
      if (in_ready) chk("R8", "in_ready outside frame", int'(cs_n), 0);
      if (prev_cs && !cs_n) begin
        chk("R7", "cs_n high gap", int'(hi_cnt >= GAP), 1);
        rx_b.delete();
        bitcnt = 0;
      end
      if (!cs_n && sclk && !prev_sclk) begin
        sh_in = ((sh_in << 1) | int'(mosi)) & 255;
        bitcnt++;
        if (bitcnt % 8 == 0) rx_b.push_back(sh_in);
      end
      if (!prev_cs && cs_n) begin
        string tag;
        chk("R2", "whole bytes in frame", bitcnt % 8, 0);
        if (exp_len.size() == 0) begin
          chk("R6", "unexpected frame", 1, 0);
        end else begin
          int n;
          n = exp_len.pop_front();
          if (exp_b[0] == 6) tag = "R3";
          else if (exp_b[0] == 2) tag = "R5";
          else tag = "R6";
          chk(tag, "frame length", rx_b.size(), n);
          for (int i = 0; i < n; i++) begin
            int e;
            e = exp_b.pop_front();
            if (i < rx_b.size()) chk(tag == "R5" ? "R4" : tag, "frame byte", rx_b[i], e);
          end
        end
        if (rx_b.size() > 0 && rx_b[0] == 2) wip_left = busy_cfg;
        if (rx_b.size() > 0 && rx_b[0] == 5 && wip_left > 0) wip_left--;
      end
      if (!cs_n && rx_b.size() >= 1 && rx_b[0] == 5 && bitcnt >= 8 && bitcnt < 16) begin
        int st;
        st = 8'h82 | (wip_left > 0 ? 1 : 0);
        miso = st[7 - (bitcnt - 8)];
      end else begin
        miso = 1'b0;
      end
      hi_cnt = cs_n ? hi_cnt + 1 : 0;
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
    if (hs_pend) void'(data_q.pop_front());
    in_valid = (data_q.size() > 0) && !(stall_en && (cyc % 7 < 3));
    in_data  = (data_q.size() > 0) ? 8'(data_q[0]) : 8'h00;
    hs_pend  = in_valid && in_ready;
  end

  task automatic run_op(input int addr, input int len, input int busyn,
                        input bit stall, input bit expect_err, input bit poke);
    int a, r, k, c;
    int d[$];
    busy_cfg = busyn;
    stall_en = stall;
    for (int i = 0; i < len; i++) begin
      d.push_back((addr * 7 + i * 13 + len) & 255);
      data_q.push_back((addr * 7 + i * 13 + len) & 255);
    end
    a = addr; r = len; k = 0;
    while (r > 0) begin
      c = 32 - (a % 32);
      if (r < c) c = r;
      exp_len.push_back(1); exp_b.push_back(6);
      exp_len.push_back(3 + c);
      exp_b.push_back(2); exp_b.push_back((a >> 8) & 255); exp_b.push_back(a & 255);
      for (int i = 0; i < c; i++) exp_b.push_back(d[k + i]);
      for (int p = 0; p < (expect_err ? PLIM : busyn + 1); p++) begin
        exp_len.push_back(2); exp_b.push_back(5); exp_b.push_back(0);
      end
      a = (a + c) & 16'hFFFF; r -= c; k += c;
    end
    @(negedge clk);
    start = 1'b1; start_addr = 16'(addr); start_len = 16'(len);
    @(negedge clk);
    start = 1'b0;
    if (len > 0) begin
      chk("R1", "busy after start", int'(busy), 1);
      chk("R10", "err cleared by start", int'(err), 0);
    end
    if (poke) begin
      repeat (150) @(negedge clk);
      chk("R11", "busy before stray start", int'(busy), 1);
      start = 1'b1; start_addr = 16'h5555; start_len = 16'd3;
      @(negedge clk);
      start = 1'b0;
    end
    while (!(done || err)) @(negedge clk);
    if (expect_err) begin
      chk("R10", "err on timeout", int'(err), 1);
      chk("R10", "no done on timeout", int'(done), 0);
      chk("R10", "idle after timeout", int'(busy), 0);
    end else begin
      chk("R9", "done pulse", int'(done), 1);
      chk("R9", "busy low with done", int'(busy), 0);
      chk("R10", "err low on success", int'(err), 0);
    end
    @(negedge clk);
    chk("R9", "done lasts one cycle", int'(done), 0);
    if (expect_err) chk("R10", "err held", int'(err), 1);
    chk("R6", "frames outstanding", exp_len.size(), 0);
    chk("R8", "bytes not consumed", data_q.size(), 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset cs_n", int'(cs_n), 1);
    chk("R1", "reset sclk", int'(sclk), 0);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset err", int'(err), 0);
    chk("R1", "reset in_ready", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_op(16'h0100, 4, 2, 0, 0, 0);
    run_op(16'h001C, 40, 1, 1, 0, 1);
    run_op(16'hFFF0, 20, 0, 0, 0, 0);
    run_op(16'h07E5, 70, 3, 1, 0, 0);
    run_op(16'h0000, 0, 0, 0, 0, 0);
    chk("R1", "zero length leaves cs_n high", int'(cs_n), 1);
    run_op(16'h0240, 32, 100, 0, 1, 0);
    run_op(16'h0A1F, 2, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule